// File: doc/BRIEF.md
# Boot-Block Flash Command Front End

This block is the control side of an asynchronous NOR-style flash with a small boot-block array. A host drives active-low chip select, output enable, write strobe, reset/power-down and write-protect pins along with an address bus. It uses a data bus that is split into an input, an output and an output-enable for an external pad. The host writes command bytes with write-strobe pulses. Program and erase each take two such writes: a setup byte, then a second write that supplies the target address and either the new data or the erase confirm code.

A system clock samples the write strobe and detects its rising edge. Address and data are taken from the last clock sample before that edge and stay latched for the whole operation. A simple write engine holds a ready flag low for a fixed number of clocks and then commits the result to a register array. The two lowest blocks are parameter blocks. While write-protect is low they refuse program and erase, and the status register records why. Reads return array contents, identifier bytes or the status register, depending on the last read-mode command.

Top module: `flash_cmd_ctl`

## Requirements
- R1: `dq_oe` is 1 only while `rp_n` is 1 and both `ce_n` and `oe_n` are 0; otherwise the pad is released.
- R2: While `rp_n` is 0 the write engine stops and the error bits clear. When `rp_n` goes back to 1, reads return array data.
- R3: Command byte 0xFF selects array reads and 0x70 selects status reads. 0x90 selects identifier reads: an even address gives `ID_MAKER` (0xA5) and an odd address gives `ID_DEVICE` (0x3C).
- R4: Writing 0x40 and then a second write of data D to address A replaces word A with (old word AND D) once the operation completes.
- R5: Writing 0x20 and then 0xD0 to address A sets all eight words of A's block (block = address bits 5:3) to 0xFF. Other blocks are unchanged.
- R6: Status bit 7 reads 0 for exactly `BUSY_CYC` clocks, starting with the clock that takes the second write, and 1 otherwise. After a setup byte or a second write, reads return status.
- R7: While `wp_n` is 0, a program aimed at block 0 or 1 sets status bits 1 and 4, and an erase aimed at block 0 or 1 sets bits 1 and 5. In both cases the array is not changed and no busy period starts.
- R8: While `wp_n` is 1, blocks 0 and 1 accept program and erase like any other block.
- R9: Status bits 1, 4 and 5 stay set through any other command until the byte 0x50 is written. That byte clears all three.
- R10: An erase setup followed by a second byte other than 0xD0 sets status bits 4 and 5 and erases nothing.
- R11: Writes that complete while the engine is busy are ignored. They neither change the read mode nor start an operation.
- R12: Pulling `rp_n` low during a busy period cancels the operation, and the addressed word keeps its old value.
- R13: A write-strobe pulse taken while `ce_n` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rp_n | input | 1 | Active-low reset / power-down |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| wp_n | input | 1 | Active-low write protect for blocks 0 and 1 |
| addr | input | AW | Word address |
| dq_in | input | DW | Data from the pad |
| dq_out | output | DW | Read data to the pad |
| dq_oe | output | 1 | Pad drive enable |

## Verification
A write-strobe release is seen two clocks later: one clock for the sampling register and one for the edge register. The command therefore takes effect on the second rising clock edge after the release. The bench's write task returns just after that edge, so a status read made at once must show busy. The busy period ends `BUSY_CYC` edges after it starts, so the bench reads busy at the last cycle and ready one cycle later. Reads are combinational from the pins and the current mode, so they are sampled 1 ns after the address and enables change, in the low half of the clock.

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int BLK_AW = 3,
  parameter int NUM_LOCK = 2,
  parameter int BUSY_CYC = 6,
  parameter logic [DW-1:0] ID_MAKER = DW'(8'hA5),
  parameter logic [DW-1:0] ID_DEVICE = DW'(8'h3C)
) (
  input  logic          clk,
  input  logic          rp_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          wp_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int BW = AW - BLK_AW;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] LOCK_LIM = BW'(NUM_LOCK);

  typedef enum logic [1:0] {M_ARRAY, M_ID, M_STAT} mode_t;
  typedef enum logic [1:0] {P_NONE, P_PROG, P_ERASE} pend_t;

  logic we_s1, we_s2, ce_s1, ce_s2;
  logic [AW-1:0] a_s1, a_s2, lat_a;
  logic [DW-1:0] d_s1, d_s2, lat_d;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_data, stat;
  logic [CW-1:0] cnt;
  logic busy, op_erase, err1, err4, err5;
  mode_t mode;
  pend_t pend;

  always_ff @(posedge clk or negedge rp_n) begin
    if (!rp_n) begin
      we_s1 <= 1'b1; we_s2 <= 1'b1; ce_s1 <= 1'b1; ce_s2 <= 1'b1;
      a_s1 <= '0; a_s2 <= '0; d_s1 <= '0; d_s2 <= '0;
    end else begin
      we_s1 <= we_n; we_s2 <= we_s1; ce_s1 <= ce_n; ce_s2 <= ce_s1;
      a_s1 <= addr;  a_s2 <= a_s1;   d_s1 <= dq_in; d_s2 <= d_s1;
    end
  end

  wire [7:0] cmd = d_s2[7:0];
  wire accept = we_s1 & ~we_s2 & ~ce_s2 & ~busy;
  wire lock_hit = ~wp_n & (a_s2[AW-1:BLK_AW] < LOCK_LIM);
  wire done = busy & (cnt == '0);
  wire clr_st = accept & (pend == P_NONE) & (cmd == 8'h50);

  always_ff @(posedge clk or negedge rp_n) begin
    if (!rp_n) begin
      mode <= M_ARRAY; pend <= P_NONE; busy <= 1'b0; cnt <= '0;
      op_erase <= 1'b0; lat_a <= '0; lat_d <= '0;
      err1 <= 1'b0; err4 <= 1'b0; err5 <= 1'b0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end else if (accept) begin
      case (pend)
        P_PROG: begin
          pend <= P_NONE; mode <= M_STAT;
          if (lock_hit) begin err1 <= 1'b1; err4 <= 1'b1; end
          else begin
            busy <= 1'b1; cnt <= CW'(BUSY_CYC - 1); op_erase <= 1'b0;
            lat_a <= a_s2; lat_d <= d_s2;
          end
        end
        P_ERASE: begin
          pend <= P_NONE; mode <= M_STAT;
          if (cmd != 8'hD0) begin err4 <= 1'b1; err5 <= 1'b1; end
          else if (lock_hit) begin err1 <= 1'b1; err5 <= 1'b1; end
          else begin
            busy <= 1'b1; cnt <= CW'(BUSY_CYC - 1); op_erase <= 1'b1;
            lat_a <= a_s2;
          end
        end
        default: begin
          case (cmd)
            8'hFF: mode <= M_ARRAY;
            8'h90: mode <= M_ID;
            8'h70: mode <= M_STAT;
            8'h50: begin err1 <= 1'b0; err4 <= 1'b0; err5 <= 1'b0; end
            8'h40: begin pend <= P_PROG;  mode <= M_STAT; end
            8'h20: begin pend <= P_ERASE; mode <= M_STAT; end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (done) begin
        if (op_erase) begin
          if ((AW'(i) >> BLK_AW) == (lat_a >> BLK_AW)) mem[i] <= '1;
        end else if (AW'(i) == lat_a) begin
          mem[i] <= mem[i] & lat_d;
        end
      end
    end
  end

  always_comb begin
    stat = '0;
    stat[7] = ~busy;
    stat[5] = err5;
    stat[4] = err4;
    stat[1] = err1;
    case (mode)
      M_ID:    rd_data = addr[0] ? ID_DEVICE : ID_MAKER;
      M_STAT:  rd_data = stat;
      default: rd_data = mem[addr];
    endcase
  end

  assign dq_oe  = rp_n & ~ce_n & ~oe_n;
  assign dq_out = dq_oe ? rd_data : '0;
endmodule

// File: rtl/flash_cmd_ctl_chk.sv
module flash_cmd_ctl_chk #(
  parameter int AW = 6,
  parameter int BLK_AW = 3,
  parameter int NUM_LOCK = 2,
  parameter int BUSY_CYC = 6,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rp_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          wp_n,
  input logic          dq_oe,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] lat_a,
  input logic          err1,
  input logic          err4,
  input logic          err5,
  input logic          clr_st
);
  AST_PAD_RELEASED: assert property (@(posedge clk)
    (!rp_n || ce_n || oe_n) |-> !dq_oe); // R1

  AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rp_n)
    $rose(busy) |-> cnt == CW'(BUSY_CYC - 1)); // R6

  AST_LOCK_SAFE: assert property (@(posedge clk) disable iff (!rp_n)
    $rose(busy) |-> ($past(wp_n) || int'(lat_a >> BLK_AW) >= NUM_LOCK)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rp_n)
    !clr_st |=> ((err1 || !$past(err1)) && (err4 || !$past(err4)) && (err5 || !$past(err5)))); // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rp_n)
    (busy && $past(busy)) |-> $stable(lat_a)); // R11
endmodule

bind flash_cmd_ctl flash_cmd_ctl_chk #(
  .AW(AW), .BLK_AW(BLK_AW), .NUM_LOCK(NUM_LOCK), .BUSY_CYC(BUSY_CYC), .CW(CW)
) u_chk (
  .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .wp_n(wp_n),
  .dq_oe(dq_oe), .busy(busy), .cnt(cnt), .lat_a(lat_a),
  .err1(err1), .err4(err4), .err5(err5), .clr_st(clr_st)
);

// File: tb/test_flash_cmd_ctl.sv
module test_flash_cmd_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC = 6;

  logic clk = 1'b0, rp_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic oe;
  int nchk = 0, nerr = 0;
  logic [7:0] m [64];
  logic [7:0] e_err = 8'h00;

  flash_cmd_ctl #(.BUSY_CYC(BUSY_CYC)) i_flash_cmd_ctl (
    .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wp_n(wp_n),
    .addr(addr), .dq_in(din), .dq_out(dout), .dq_oe(oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    nchk++;
    if (act !== exp_v) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk); ce_n = ~sel; addr = a; din = d; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic locked(input logic [5:0] a, input logic wp);
    return !wp && (a[5:3] < 3'd2);
  endfunction

  function automatic logic [7:0] exp_stat(input logic ready, input logic [7:0] err);
    return {ready, 7'b0} | err;
  endfunction

  task automatic do_prog(input logic [5:0] a, input logic [7:0] d, input logic wp, input string req);
    logic [7:0] v;
    wp_n = wp;
    wr(a, 8'h40); wr(a, d); idle(BUSY_CYC + 2);
    if (locked(a, wp)) e_err |= 8'h12; else m[a] &= d;
    rd(a, v); check(req, v, exp_stat(1'b1, e_err));
    wr(0, 8'h50); e_err = 8'h00; wr(0, 8'hFF); wp_n = 1'b1;
    rd(a, v); check(req, v, m[a]);
  endtask

  task automatic do_erase(input logic [5:0] a, input logic wp, input string req);
    logic [7:0] v;
    wp_n = wp;
    wr(a, 8'h20); wr(a, 8'hD0); idle(BUSY_CYC + 2);
    if (locked(a, wp)) e_err |= 8'h22;
    else for (int k = 0; k < 8; k++) m[{a[5:3], 3'(k)}] = 8'hFF;
    rd(a, v); check(req, v, exp_stat(1'b1, e_err));
    wr(0, 8'h50); e_err = 8'h00; wr(0, 8'hFF); wp_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      rd({a[5:3], 3'(k)}, v); check(req, v, m[{a[5:3], 3'(k)}]);
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    // R1: reset low with enables asserted releases the pad
    ce_n = 1'b0; oe_n = 1'b0;
    idle(2); #1 check("R1 rst", {7'b0, oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
    rp_n = 1'b1; idle(2);
    for (int b = 0; b < 8; b++) do_erase(6'(b * 8), 1'b1, "R5 init");

    // R3 read modes
    wr(0, 8'h90);
    rd(0, v); check("R3 maker", v, 8'hA5);
    rd(1, v); check("R3 device", v, 8'h3C);
    wr(0, 8'h70); rd(9, v); check("R3 status", v, 8'h80);
    wr(0, 8'hFF); rd(9, v); check("R3 array", v, 8'hFF);
    addr = 6'd9; ce_n = 1'b0; oe_n = 1'b1;
    #1 check("R1 oe_n high", {7'b0, oe}, 8'h00);
    ce_n = 1'b1;

    // R6 busy window and R11 write ignored while busy
    wp_n = 1'b1;
    wr(6'd20, 8'h40); rd(0, v); check("R6 setup->status", v, 8'h80);
    wr(6'd20, 8'h5A);
    rd(0, v); check("R6 busy start", v, 8'h00);
    wr(0, 8'hFF);
    rd(0, v); check("R6 busy last", v, 8'h00);
    idle(1);
    rd(0, v); check("R6 ready", v, 8'h80);
    rd(20, v); check("R11 mode kept", v, 8'h80);
    m[20] = 8'h5A;
    wr(0, 8'hFF); rd(20, v); check("R4 and", v, 8'h5A);
    do_prog(20, 8'hF0, 1'b1, "R4 and2");

    // R8 unlocked parameter blocks, then R7 locked refusals
    do_prog(6'd3, 8'h3C, 1'b1, "R8 prog");
    do_prog(6'd9, 8'h81, 1'b1, "R8 prog b1");
    do_prog(6'd3, 8'h00, 1'b0, "R7 prog lock");
    do_erase(6'd9, 1'b0, "R7 erase lock");

    // R9 sticky errors
    wp_n = 1'b0;
    wr(6'd2, 8'h40); wr(6'd2, 8'h00); wp_n = 1'b1;
    wr(0, 8'hFF); wr(0, 8'h90); wr(0, 8'h70);
    rd(0, v); check("R9 sticky", v, 8'h92);
    wr(0, 8'h50); rd(0, v); check("R9 clear", v, 8'h80);
    wr(0, 8'hFF); rd(2, v); check("R7 unchanged", v, m[2]);

    // R10 bad erase confirm
    do_prog(6'd40, 8'h0F, 1'b1, "R4 prog40");
    wr(6'd40, 8'h20); wr(6'd40, 8'h33); idle(BUSY_CYC + 2);
    rd(0, v); check("R10 status", v, 8'hB0);
    wr(0, 8'h50); wr(0, 8'hFF);
    rd(40, v); check("R10 no erase", v, 8'h0F);

    // R13 strobe without chip select
    wr(0, 8'h90, 1'b0);
    rd(40, v); check("R13 ignored", v, 8'h0F);

    // R12 reset during busy, R2 array mode after reset
    wr(6'd50, 8'h40); wr(6'd50, 8'h00); idle(1);
    rp_n = 1'b0; idle(1);
    rd(50, v); check("R1 rp low", {7'b0, oe}, 8'h00);
    idle(1); rp_n = 1'b1; idle(2);
    rd(50, v); check("R12 abort", v, m[50]);
    rd(20, v); check("R2 array mode", v, m[20]);
    wr(0, 8'h70); rd(0, v); check("R2 status clear", v, 8'h80);
    wr(0, 8'hFF);

    // R4 R5 R7 R8 random mix
    for (int it = 0; it < 40; it++) begin
      logic [5:0] a;
      logic [7:0] d;
      logic w;
      a = 6'($urandom_range(0, 63));
      d = 8'($urandom_range(0, 255));
      w = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) do_erase(a, w, "R5 rand erase");
      else do_prog(a, d, w, "R4 rand prog");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule